// File: doc/BRIEF.md
# Boot Vector and Stack Sequencer

This block is the memory-side sequencer of a small CPU with a 16-bit address space and byte-wide data. It owns the program counter and an 8-bit stack index. It runs every operation that needs several memory cycles: the boot jump, stack push, stack pop and interrupt entry. Instruction decode and ALU work belong to neighbouring logic, which raises one of three request strobes and reads back the results.

Three words in low memory steer the sequencer. Each is stored big-endian, with the high byte at the lower address. Bytes 0 and 1 hold the address the program starts at. Bytes 2 and 3 hold the stack base. Bytes 4 and 5 hold the interrupt handler address. None of these words is held in a register between operations. The stack base is fetched again for every stack access, and the handler address is fetched again for every interrupt entry, so software may move either one at any time.

The memory port is synchronous. A read issued in one cycle returns its byte on `mem_rdata` in the next cycle. A write takes effect at the clock edge that ends the cycle in which it is issued.

Top module: `stack_vector_seq`

## Requirements
- R1: During reset `busy` is 1, `done` is 0, `mem_wr` is 0 and `sp_idx` is 0. After reset is released, the block reads address 0 (high byte) and then address 1 (low byte), and loads `pc` with the resulting big-endian word. `busy` stays high for 3 cycles from the first cycle out of reset.
- R2: A push request accepted while idle keeps `busy` high for 3 cycles. In that time the block reads the stack base from addresses 2 (high byte) and 3 (low byte). It then writes `push_data`, captured when the request was accepted, to address base + `sp_idx`, and increments `sp_idx`.
- R3: A pop request keeps `busy` high for 4 cycles. The block reads the stack base, decrements `sp_idx`, reads address base + new `sp_idx`, and presents that byte on `pop_data`.
- R4: The stack base is read from memory again at the start of every push, pop and interrupt entry. A change to addresses 2–3 made between operations takes effect at the next operation.
- R5: An interrupt request keeps `busy` high for 7 cycles. The block reads the stack base and writes the low byte of `pc` to base + `sp_idx`. It then writes the high byte of `pc` to the next stack slot, so `sp_idx` advances by 2. Finally it loads `pc` with the big-endian word at addresses 4–5.
- R6: The handler address is read from addresses 4–5 again on every interrupt entry. The read of address 4 comes in the cycle right after the second stack write.
- R7: `sp_idx` is 8 bits wide and wraps modulo 256: a pop at 0 gives 255, and a push at 255 gives 0. It is zero-extended before it is added to the 16-bit base.
- R8: Requests that arrive while `busy` is high are ignored. When several requests arrive together while idle, interrupt wins over pop, and pop wins over push.
- R9: `done` is a one-cycle pulse in the first idle cycle after a push, pop or interrupt entry completes, and `busy` is low whenever `done` is high.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle, and `mem_wr` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_push | input | 1 | Request a stack push of `push_data` |
| req_pop | input | 1 | Request a stack pop into `pop_data` |
| req_irq | input | 1 | Request interrupt entry |
| push_data | input | 8 | Byte to push, sampled when the request is accepted |
| pop_data | output | 8 | Byte returned by the last pop |
| pc | output | 16 | Program counter |
| sp_idx | output | 8 | Stack index |
| busy | output | 1 | An operation or the boot fetch is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |

## Verification
The assertions assume that memory returns read data exactly one cycle after each read. They also assume that request strobes are only acted on while the block is idle, so the index changes by exactly one on each push or pop step. The bench memory model is a registered array with that one-cycle latency. The bench raises requests for a single cycle, except in the busy-ignore scenario, which deliberately strobes a request mid-operation to show it has no effect. Vector and base words are rewritten only while the block is idle.

// File: rtl/svs_pkg.sv
// Shared types for the boot vector and stack sequencer.
// Assumes a two-byte address word and byte-wide memory.
package svs_pkg;

    typedef enum logic [3:0] {
        ST_BOOT_H, ST_BOOT_L, ST_BOOT_J, ST_IDLE,
        ST_BASE_H, ST_BASE_L, ST_PUSH,  ST_POP_A, ST_POP_D,
        ST_IRQ_W0, ST_IRQ_W1, ST_VEC_H, ST_VEC_L, ST_VEC_J
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_PUSH, OP_POP, OP_IRQ
    } seq_op_t;

endpackage

// File: rtl/svs_addr_gen.sv
// Stack address generator: base plus the zero-extended index.
// The index may optionally be decremented first (modulo 2**IDX_W).
// Assumes IDX_W <= ADDR_W.
module svs_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              pre_dec,
    output logic [ADDR_W-1:0] addr
);

    logic [IDX_W-1:0] eff_idx;

    // Pick the effective index, wrapping within its own width, then add it to the base.
    always_comb begin
        eff_idx = pre_dec ? idx - IDX_W'(1) : idx;
        addr    = base + ADDR_W'(eff_idx);
    end

endmodule

// File: rtl/svs_index.sv
// Stack index register; counts up or down by one and wraps modulo 2**IDX_W.
// Assumes the controller never asks for both directions at once.
module svs_index #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [IDX_W-1:0] idx
);

    // Update the index register.
    always_ff @(posedge clk) begin
        if (!rst_n)   idx <= '0;
        else if (inc) idx <= idx + IDX_W'(1);
        else if (dec) idx <= idx - IDX_W'(1);
    end

    // R7: one step per cycle in a single direction
    assert_single_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));

endmodule

// File: rtl/stack_vector_seq.sv
// Boot vector and stack sequencer.
// Fetches the start vector after reset, and runs push, pop and interrupt entry
// against a byte-wide synchronous memory (one-cycle read latency).
// Stack base (bytes 2-3) and handler (bytes 4-5) are re-read on every use.
// Assumes ADDR_W == 2*DATA_W, with words stored high byte first.
module stack_vector_seq #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_push,
    input  logic              req_pop,
    input  logic              req_irq,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  sp_idx,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import svs_pkg::*;

    localparam logic [ADDR_W-1:0] VEC_START_HI = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] VEC_START_LO = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] VEC_BASE_HI  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] VEC_BASE_LO  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] VEC_HNDL_HI  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] VEC_HNDL_LO  = ADDR_W'(5);

    seq_state_t        state, state_nx;
    seq_op_t           op_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] base_lo_q;
    logic [ADDR_W-1:0] stk_base;
    logic [ADDR_W-1:0] stk_addr;
    logic              idx_inc, idx_dec, pre_dec;
    logic              any_req;

    assign any_req = req_push | req_pop | req_irq;
    assign busy    = (state != ST_IDLE);

    // Next-state selection for the sequencer.
    always_comb begin
        state_nx = state;
        case (state)
            ST_BOOT_H: state_nx = ST_BOOT_L;
            ST_BOOT_L: state_nx = ST_BOOT_J;
            ST_BOOT_J: state_nx = ST_IDLE;
            ST_IDLE:   if (any_req) state_nx = ST_BASE_H;
            ST_BASE_H: state_nx = ST_BASE_L;
            ST_BASE_L: state_nx = (op_q == OP_IRQ) ? ST_IRQ_W0 :
                                  (op_q == OP_POP) ? ST_POP_A  : ST_PUSH;
            ST_PUSH:   state_nx = ST_IDLE;
            ST_POP_A:  state_nx = ST_POP_D;
            ST_POP_D:  state_nx = ST_IDLE;
            ST_IRQ_W0: state_nx = ST_IRQ_W1;
            ST_IRQ_W1: state_nx = ST_VEC_H;
            ST_VEC_H:  state_nx = ST_VEC_L;
            ST_VEC_L:  state_nx = ST_VEC_J;
            ST_VEC_J:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register; reset starts the boot fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BOOT_H;
        else        state <= state_nx;
    end

    // Latch the winning request and its data when idle (interrupt > pop > push).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_PUSH;
            data_q <= '0;
        end else if (state == ST_IDLE && any_req) begin
            op_q   <= req_irq ? OP_IRQ : (req_pop ? OP_POP : OP_PUSH);
            data_q <= push_data;
        end
    end

    // Capture the high byte of whichever word is being fetched, and the base low byte for the second interrupt write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q      <= '0;
            base_lo_q <= '0;
        end else begin
            if (state == ST_BOOT_L || state == ST_BASE_L || state == ST_VEC_L)
                hi_q <= mem_rdata;
            if (state == ST_IRQ_W0)
                base_lo_q <= mem_rdata;
        end
    end

    // Program counter, pop result and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            pop_data <= '0;
            done     <= 1'b0;
        end else begin
            if (state == ST_BOOT_J || state == ST_VEC_J)
                pc <= {hi_q, mem_rdata};
            if (state == ST_POP_D)
                pop_data <= mem_rdata;
            done <= (state == ST_PUSH) || (state == ST_POP_D) || (state == ST_VEC_J);
        end
    end

    // Stack base: the low byte arrives live in the first stack-access cycle, and comes from its latch afterwards.
    assign stk_base = (state == ST_IRQ_W1) ? {hi_q, base_lo_q} : {hi_q, mem_rdata};
    assign pre_dec  = (state == ST_POP_A);
    assign idx_inc  = (state == ST_PUSH) || (state == ST_IRQ_W0) || (state == ST_IRQ_W1);
    assign idx_dec  = (state == ST_POP_A);

    svs_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .base    (stk_base),
        .idx     (sp_idx),
        .pre_dec (pre_dec),
        .addr    (stk_addr)
    );

    svs_index #(.IDX_W(IDX_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (idx_inc),
        .dec   (idx_dec),
        .idx   (sp_idx)
    );

    // Drive the memory port from the current state.
    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        case (state)
            ST_BOOT_H: begin mem_rd = 1'b1; mem_addr = VEC_START_HI; end
            ST_BOOT_L: begin mem_rd = 1'b1; mem_addr = VEC_START_LO; end
            ST_BASE_H: begin mem_rd = 1'b1; mem_addr = VEC_BASE_HI;  end
            ST_BASE_L: begin mem_rd = 1'b1; mem_addr = VEC_BASE_LO;  end
            ST_VEC_H:  begin mem_rd = 1'b1; mem_addr = VEC_HNDL_HI;  end
            ST_VEC_L:  begin mem_rd = 1'b1; mem_addr = VEC_HNDL_LO;  end
            ST_POP_A:  begin mem_rd = 1'b1; mem_addr = stk_addr;     end
            ST_PUSH:   begin mem_wr = 1'b1; mem_addr = stk_addr; mem_wdata = data_q; end
            ST_IRQ_W0: begin mem_wr = 1'b1; mem_addr = stk_addr; mem_wdata = pc[DATA_W-1:0]; end
            ST_IRQ_W1: begin mem_wr = 1'b1; mem_addr = stk_addr; mem_wdata = pc[ADDR_W-1:DATA_W]; end
            default: ;
        endcase
    end

    // R10: a single access per cycle, and writes only inside an operation
    assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_write_in_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> busy);

    // R9: completion pulse lands in the first idle cycle
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R2: the push write step advances the index by one
    assert_push_bump_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH) |=> (sp_idx == IDX_W'($past(sp_idx) + IDX_W'(1))));

    // R3: the pop address step lowers the index by one
    assert_pop_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP_A) |=> (sp_idx == IDX_W'($past(sp_idx) - IDX_W'(1))));

    // R6: after the second return-address write, the handler high byte is read
    assert_vector_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && state == ST_IRQ_W1) |=> (mem_rd && mem_addr == VEC_HNDL_HI));

endmodule

// File: tb/stack_vector_seq_test.sv
module stack_vector_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_push, req_pop, req_irq;
    logic [7:0]  push_data;
    logic [7:0]  pop_data;
    logic [15:0] pc;
    logic [7:0]  sp_idx;
    logic        busy, done;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem [0:4095];

    int n_tests = 0;
    int n_fail  = 0;
    int clash   = 0;

    always #10 clk = ~clk;

    stack_vector_seq uut (
        .clk(clk), .rst_n(rst_n),
        .req_push(req_push), .req_pop(req_pop), .req_irq(req_irq),
        .push_data(push_data), .pop_data(pop_data), .pc(pc), .sp_idx(sp_idx),
        .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Registered memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    end

    // R10 monitor: count cycles with a read and a write together, or a write while idle.
    always @(negedge clk) begin
        if (rst_n && ((mem_rd && mem_wr) || (mem_wr && !busy))) clash++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Raise one request for a cycle, then count busy cycles and check the done pulse.
    task automatic run_op(input bit p, input bit o, input bit i, input logic [7:0] d,
                          output int cycles);
        @(negedge clk);
        req_push = p; req_pop = o; req_irq = i; push_data = d;
        @(negedge clk);
        req_push = 0; req_pop = 0; req_irq = 0;
        cycles = 0;
        while (busy && cycles < 40) begin
            cycles++;
            @(negedge clk);
        end
        check(done === 1'b1, "R9 done at completion", int'(done), 1);
        @(negedge clk);
        check(done === 1'b0, "R9 done lasts one cycle", int'(done), 0);
    endtask

    task automatic t_reset_boot();
        int cyc;
        rst_n = 0; req_push = 0; req_pop = 0; req_irq = 0; push_data = 0;
        mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'h08; mem[3] = 8'h00;
        mem[4] = 8'h0A; mem[5] = 8'h50;
        repeat (3) @(negedge clk);
        check(busy === 1'b1 && done === 1'b0 && mem_wr === 1'b0, "R1 reset outputs",
              int'({busy, done, mem_wr}), 3'b100);
        check(sp_idx === 8'h00, "R1 reset index", int'(sp_idx), 0);
        rst_n = 1;
        cyc = 0;
        while (busy && cyc < 40) begin cyc++; @(negedge clk); end
        check(cyc == 3, "R1 boot busy cycles", cyc, 3);
        check(pc === 16'h1234, "R1 start vector big-endian", int'(pc), 16'h1234);
    endtask

    task automatic t_push_pop();
        int cyc;
        run_op(1, 0, 0, 8'hA5, cyc);
        check(cyc == 3, "R2 push busy cycles", cyc, 3);
        check(mem[12'h800] === 8'hA5, "R2 push data at base+0", int'(mem[12'h800]), 8'hA5);
        check(sp_idx === 8'd1, "R2 index after push", int'(sp_idx), 1);
        run_op(1, 0, 0, 8'h3C, cyc);
        check(mem[12'h801] === 8'h3C, "R2 push data at base+1", int'(mem[12'h801]), 8'h3C);
        run_op(0, 1, 0, 8'h00, cyc);
        check(cyc == 4, "R3 pop busy cycles", cyc, 4);
        check(pop_data === 8'h3C, "R3 pop data", int'(pop_data), 8'h3C);
        check(sp_idx === 8'd1, "R3 index after pop", int'(sp_idx), 1);
    endtask

    task automatic t_base_reread();
        int cyc;
        mem[2] = 8'h09; mem[3] = 8'h10;
        run_op(1, 0, 0, 8'h77, cyc);
        check(mem[12'h911] === 8'h77, "R4 push uses new base", int'(mem[12'h911]), 8'h77);
        mem[12'h911] = 8'h78;
        run_op(0, 1, 0, 8'h00, cyc);
        check(pop_data === 8'h78, "R4 pop uses new base", int'(pop_data), 8'h78);
    endtask

    task automatic t_irq();
        int cyc;
        run_op(0, 0, 1, 8'h00, cyc);
        check(cyc == 7, "R5 interrupt busy cycles", cyc, 7);
        check(mem[12'h911] === 8'h34, "R5 pc low byte first", int'(mem[12'h911]), 8'h34);
        check(mem[12'h912] === 8'h12, "R5 pc high byte second", int'(mem[12'h912]), 8'h12);
        check(sp_idx === 8'd3, "R5 index advanced by 2", int'(sp_idx), 3);
        check(pc === 16'h0A50, "R5 jump to handler", int'(pc), 16'h0A50);
        mem[4] = 8'h0B; mem[5] = 8'h66;
        run_op(0, 0, 1, 8'h00, cyc);
        check(mem[12'h913] === 8'h50 && mem[12'h914] === 8'h0A, "R6 nested return address",
              int'({mem[12'h913], mem[12'h914]}), 16'h500A);
        check(pc === 16'h0B66, "R6 handler re-read", int'(pc), 16'h0B66);
    endtask

    task automatic t_wrap();
        int cyc;
        for (int k = 0; k < 5; k++) run_op(0, 1, 0, 8'h00, cyc);
        check(sp_idx === 8'd0, "R7 index drained", int'(sp_idx), 0);
        mem[12'hA0F] = 8'h5E;
        run_op(0, 1, 0, 8'h00, cyc);
        check(sp_idx === 8'hFF, "R7 pop at 0 wraps to 255", int'(sp_idx), 255);
        check(pop_data === 8'h5E, "R7 zero-extended address", int'(pop_data), 8'h5E);
        run_op(1, 0, 0, 8'h81, cyc);
        check(sp_idx === 8'h00 && mem[12'hA0F] === 8'h81, "R7 push at 255 wraps to 0",
              int'(sp_idx), 0);
        run_op(1, 0, 0, 8'h82, cyc);
        check(mem[12'h910] === 8'h82, "R7 push after wrap at base", int'(mem[12'h910]), 8'h82);
    endtask

    task automatic t_busy_ignore();
        int cyc;
        logic [7:0] idx0;
        idx0 = sp_idx;
        @(negedge clk);
        req_push = 1; push_data = 8'h11;
        @(negedge clk);
        req_push = 0; req_pop = 1;
        @(negedge clk);
        req_pop = 0;
        cyc = 0;
        while (busy && cyc < 40) begin cyc++; @(negedge clk); end
        repeat (3) begin
            check(busy === 1'b0, "R8 request during busy ignored", int'(busy), 0);
            @(negedge clk);
        end
        check(sp_idx === idx0 + 8'd1, "R8 only the push took effect", int'(sp_idx), int'(idx0 + 8'd1));
    endtask

    task automatic t_priority();
        int cyc;
        logic [7:0] idx0;
        idx0 = sp_idx;
        mem[4] = 8'h0C; mem[5] = 8'h20;
        run_op(1, 1, 1, 8'h44, cyc);
        check(cyc == 7, "R8 interrupt wins", cyc, 7);
        check(sp_idx === idx0 + 8'd2 && pc === 16'h0C20, "R8 interrupt effect",
              int'(pc), 16'h0C20);
        idx0 = sp_idx;
        run_op(1, 1, 0, 8'h45, cyc);
        check(cyc == 4 && sp_idx === idx0 - 8'd1, "R8 pop beats push", cyc, 4);
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
        t_reset_boot();
        t_push_pop();
        t_base_reread();
        t_irq();
        t_wrap();
        t_busy_ignore();
        t_priority();
        check(clash == 0, "R10 port exclusivity", clash, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule